// File: doc/BRIEF.md
# Multi-Source Configuration Byte Receiver

This block is the receive front end of a reconfigurable fabric's configuration loader. Configuration data can arrive on any of three inputs: an asynchronous serial line (8 data bits, no parity, one stop bit), a two-wire serial link made of a clock pin and a data pin, and a parallel byte port with a valid strobe. The block turns each source's traffic into whole bytes. It picks one source by a fixed ranking and hands the byte on as a single-cycle strobe. The strobe carries a field naming the source, and a frame loader further down the chain consumes it.

Two status outputs follow the byte stream. The transfer flag goes high with the first byte and drops after a programmable stretch of silence. The indicator LED is lit steadily while a transfer is under way and blinks slowly when the link is idle. The block stays in reset until two conditions hold: the external reset is released, and the clock source reports lock. The combined reset is released into the clock domain through a two-stage synchronizer.

The serial receiver is a four-state machine:
- `U_IDLE` goes to `U_START` on a low line.
- `U_START` goes to `U_DATA` if the line is still low at the half-bit point, and back to `U_IDLE` otherwise.
- `U_DATA` goes to `U_STOP` after the eighth sample.
- `U_STOP` goes to `U_IDLE` at the stop-bit sample point.

The link monitor has two states:
- `L_IDLE` goes to `L_ACTIVE` on any delivered byte.
- `L_ACTIVE` goes back to `L_IDLE` once the timeout expires with no byte.

Top module: `cfg_rx_frontend`

## Requirements
- R1: Priority is serial line over two-wire link over parallel port. While the serial receiver is inside a frame, the two-wire shifter is held cleared, so its clock edges are lost. While either serial path is busy (serial frame in progress, or the two-wire bit count is non-zero), a parallel strobe is discarded.
- R2: Every delivered byte appears on `cfg_data` during exactly one cycle with `cfg_valid` high. `cfg_src` names the source: 2'b01 for the serial line, 2'b10 for the two-wire link, 2'b11 for the parallel port. 2'b00 is never shown with a valid byte.
- R3: The serial receiver samples a double-synchronized line, least significant bit first. Each bit is sampled at its midpoint. The bit period is round(CLK_HZ/BAUD) clocks, which is 174 for the default 10 MHz clock and 57600 baud.
- R4: A low pulse that is gone before the half-bit point is treated as noise. It yields no byte and no framing error.
- R5: A frame whose stop bit samples low is dropped, and `frame_err` pulses high for one cycle.
- R6: The two-wire link shifts in the data pin on each rising edge of its clock pin, most significant bit first. It delivers a byte on the eighth edge.
- R7: A parallel strobe is delivered with its byte when neither serial path is busy.
- R8: `xfer_active` rises in the cycle after a byte is delivered. It stays high until IDLE_TIMEOUT cycles (65536 by default) pass with no further byte, then falls.
- R9: While `xfer_active` is high, `rx_led` is held at 1. While the link is idle, `rx_led` follows the top bit of a free-running counter that is BLINK_LOG2 bits wide (22 by default), so it toggles every 2^(BLINK_LOG2-1) cycles.
- R10: While `ext_rst_n` or `clk_locked` is low, no byte is delivered and `xfer_active` is 0. Any traffic offered during that time is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| ext_rst_n | input | 1 | External active-low reset |
| clk_locked | input | 1 | Clock source lock indication |
| uart_rx | input | 1 | Asynchronous serial data line, idle high |
| bb_sclk | input | 1 | Two-wire link clock pin |
| bb_sdata | input | 1 | Two-wire link data pin |
| par_valid | input | 1 | Parallel byte strobe |
| par_data | input | 8 | Parallel byte |
| cfg_valid | output | 1 | One-cycle byte strobe toward the frame loader |
| cfg_data | output | 8 | Delivered byte |
| cfg_src | output | 2 | Source of the delivered byte |
| frame_err | output | 1 | One-cycle pulse on a bad stop bit |
| xfer_active | output | 1 | High for the duration of a transfer |
| rx_led | output | 1 | Solid during transfer, blinking when idle |

## Verification
The byte path is driven with random bytes on randomly chosen sources, one source at a time. This shows that the bit order and the source field are right for each path on its own. Directed overlaps then start a two-wire byte or a parallel strobe inside a serial frame, and a parallel strobe inside a two-wire byte. Only the higher-ranked byte may come out, which separates correct ranking from simple first-come merging. A short low glitch and a frame with a low stop bit separate start-bit validation and stop-bit checking from an unconditional receiver. Watching the LED and the transfer flag just before and just after the timeout separates solid-while-active from blinking-while-idle.

// File: rtl/cfg_rx_pkg.sv
package cfg_rx_pkg;
    typedef enum logic [1:0] {
        SRC_NONE = 2'b00,
        SRC_UART = 2'b01,
        SRC_BB   = 2'b10,
        SRC_PAR  = 2'b11
    } cfg_src_e;
endpackage

// File: rtl/cfg_uart_rx.sv
module cfg_uart_rx #(
    parameter int CLK_HZ = 10_000_000,
    parameter int BAUD   = 57_600,
    parameter int DW     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx,
    output logic          byte_vld,
    output logic [DW-1:0] byte_data,
    output logic          frame_err,
    output logic          busy
);
    localparam int DIV  = (CLK_HZ + BAUD / 2) / BAUD;
    localparam int HALF = DIV / 2;
    localparam int CW   = $clog2(DIV);
    localparam int IW   = (DW > 1) ? $clog2(DW) : 1;

    typedef enum logic [1:0] {U_IDLE, U_START, U_DATA, U_STOP} ust_e;

    ust_e            state, nxt;
    logic [1:0]      rx_q;
    logic            rx_s;
    logic [CW-1:0]   cnt;
    logic [IW-1:0]   bit_idx;
    logic [DW-1:0]   shreg;
    logic            half_hit, full_hit;

    assign rx_s     = rx_q[1];
    assign half_hit = (cnt == CW'(HALF - 1));
    assign full_hit = (cnt == CW'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= 2'b11;
        else        rx_q <= {rx_q[0], rx};
    end

    always_comb begin
        nxt = state;
        unique case (state)
            U_IDLE:  if (!rx_s) nxt = U_START;
            U_START: if (half_hit) nxt = rx_s ? U_IDLE : U_DATA;
            U_DATA:  if (full_hit && bit_idx == IW'(DW - 1)) nxt = U_STOP;
            U_STOP:  if (full_hit) nxt = U_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= U_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
        end else begin
            if (state == U_IDLE || (state == U_START && half_hit) || full_hit)
                cnt <= '0;
            else
                cnt <= cnt + 1'b1;
            if (state == U_START)
                bit_idx <= '0;
            else if (state == U_DATA && full_hit) begin
                shreg   <= {rx_s, shreg[DW-1:1]};
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    always_comb begin
        busy      = (state != U_IDLE);
        byte_vld  = (state == U_STOP) && full_hit && rx_s;
        frame_err = (state == U_STOP) && full_hit && !rx_s;
        byte_data = shreg;
    end

    a_r3_idle_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> !busy);
    a_r5_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);
    a_r4_start_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == U_IDLE && rx_s) |=> !busy);
endmodule

// File: rtl/cfg_bitbang_rx.sv
module cfg_bitbang_rx #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          sclk,
    input  logic          sdata,
    output logic          byte_vld,
    output logic [DW-1:0] byte_data,
    output logic          busy
);
    localparam int IW = (DW > 1) ? $clog2(DW) : 1;

    logic [1:0]    sclk_q, sdat_q;
    logic          sclk_d;
    logic          rise;
    logic [IW-1:0] cnt;
    logic [DW-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= '0;
            sdat_q <= '0;
            sclk_d <= 1'b0;
        end else begin
            sclk_q <= {sclk_q[0], sclk};
            sdat_q <= {sdat_q[0], sdata};
            sclk_d <= sclk_q[1];
        end
    end

    assign rise = sclk_q[1] && !sclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            shreg <= '0;
        end else if (hold) begin
            cnt   <= '0;
            shreg <= '0;
        end else if (rise) begin
            shreg <= {shreg[DW-2:0], sdat_q[1]};
            cnt   <= (cnt == IW'(DW - 1)) ? '0 : cnt + 1'b1;
        end
    end

    always_comb begin
        busy      = (cnt != '0);
        byte_vld  = rise && !hold && (cnt == IW'(DW - 1));
        byte_data = {shreg[DW-2:0], sdat_q[1]};
    end

    a_r1_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !busy);
    a_r6_byte_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> !busy);
endmodule

// File: rtl/cfg_src_arb.sv
module cfg_src_arb
    import cfg_rx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          u_vld,
    input  logic [DW-1:0] u_data,
    input  logic          u_busy,
    input  logic          b_vld,
    input  logic [DW-1:0] b_data,
    input  logic          b_busy,
    input  logic          p_vld,
    input  logic [DW-1:0] p_data,
    output logic          b_hold,
    output logic          out_vld,
    output logic [DW-1:0] out_data,
    output cfg_src_e      out_src
);
    logic p_acc;

    assign b_hold = u_busy;
    assign p_acc  = p_vld && !u_busy && !b_busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_data <= '0;
            out_src  <= SRC_NONE;
        end else begin
            out_vld <= u_vld || b_vld || p_acc;
            if (u_vld) begin
                out_data <= u_data;
                out_src  <= SRC_UART;
            end else if (b_vld) begin
                out_data <= b_data;
                out_src  <= SRC_BB;
            end else if (p_acc) begin
                out_data <= p_data;
                out_src  <= SRC_PAR;
            end else begin
                out_src  <= SRC_NONE;
            end
        end
    end

    a_r1_single_source: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({u_vld, b_vld, p_acc}));
    a_r1_par_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (p_vld && (u_busy || b_busy)) |=> !(out_vld && out_src == SRC_PAR));
    a_r2_src_named: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (out_src != SRC_NONE));
endmodule

// File: rtl/cfg_link_status.sv
module cfg_link_status #(
    parameter int IDLE_TIMEOUT = 65536,
    parameter int BLINK_LOG2   = 22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic byte_seen,
    output logic active,
    output logic led
);
    localparam int TW = $clog2(IDLE_TIMEOUT);

    typedef enum logic {L_IDLE, L_ACTIVE} lst_e;

    lst_e                  state, nxt;
    logic [TW-1:0]         timer;
    logic [BLINK_LOG2-1:0] blink;
    logic                  expired;

    assign expired = (timer == TW'(IDLE_TIMEOUT - 1));

    always_comb begin
        nxt = state;
        unique case (state)
            L_IDLE:   if (byte_seen) nxt = L_ACTIVE;
            L_ACTIVE: if (!byte_seen && expired) nxt = L_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= L_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer <= '0;
            blink <= '0;
        end else begin
            blink <= blink + 1'b1;
            if (byte_seen || state == L_IDLE) timer <= '0;
            else                              timer <= timer + 1'b1;
        end
    end

    always_comb begin
        active = (state == L_ACTIVE);
        led    = active ? 1'b1 : blink[BLINK_LOG2-1];
    end

    a_r8_byte_arms: assert property (@(posedge clk) disable iff (!rst_n)
        byte_seen |=> active);
    a_r9_led_solid: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(active) && active) |-> $stable(led));
endmodule

// File: rtl/cfg_rx_frontend.sv
module cfg_rx_frontend
    import cfg_rx_pkg::*;
#(
    parameter int CLK_HZ       = 10_000_000,
    parameter int BAUD         = 57_600,
    parameter int IDLE_TIMEOUT = 65536,
    parameter int BLINK_LOG2   = 22
) (
    input  logic       clk,
    input  logic       ext_rst_n,
    input  logic       clk_locked,
    input  logic       uart_rx,
    input  logic       bb_sclk,
    input  logic       bb_sdata,
    input  logic       par_valid,
    input  logic [7:0] par_data,
    output logic       cfg_valid,
    output logic [7:0] cfg_data,
    output logic [1:0] cfg_src,
    output logic       frame_err,
    output logic       xfer_active,
    output logic       rx_led
);
    localparam int DW = 8;

    logic          rst_raw_n, rst_n;
    logic [1:0]    rst_q;
    logic          u_vld, u_busy, b_vld, b_busy, b_hold;
    logic [DW-1:0] u_data, b_data;
    cfg_src_e      src_e;

    assign rst_raw_n = ext_rst_n & clk_locked;

    always_ff @(posedge clk or negedge rst_raw_n) begin
        if (!rst_raw_n) rst_q <= 2'b00;
        else            rst_q <= {rst_q[0], 1'b1};
    end
    assign rst_n = rst_q[1];

    cfg_uart_rx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DW(DW)) uart_i (
        .clk(clk), .rst_n(rst_n), .rx(uart_rx),
        .byte_vld(u_vld), .byte_data(u_data), .frame_err(frame_err), .busy(u_busy)
    );

    cfg_bitbang_rx #(.DW(DW)) bb_i (
        .clk(clk), .rst_n(rst_n), .hold(b_hold), .sclk(bb_sclk), .sdata(bb_sdata),
        .byte_vld(b_vld), .byte_data(b_data), .busy(b_busy)
    );

    cfg_src_arb #(.DW(DW)) arb_i (
        .clk(clk), .rst_n(rst_n),
        .u_vld(u_vld), .u_data(u_data), .u_busy(u_busy),
        .b_vld(b_vld), .b_data(b_data), .b_busy(b_busy),
        .p_vld(par_valid), .p_data(par_data),
        .b_hold(b_hold), .out_vld(cfg_valid), .out_data(cfg_data), .out_src(src_e)
    );
    assign cfg_src = src_e;

    cfg_link_status #(.IDLE_TIMEOUT(IDLE_TIMEOUT), .BLINK_LOG2(BLINK_LOG2)) stat_i (
        .clk(clk), .rst_n(rst_n), .byte_seen(cfg_valid),
        .active(xfer_active), .led(rx_led)
    );

    a_r10_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |-> (!cfg_valid && !xfer_active));
endmodule

// File: tb/cfg_rx_frontend_tb.sv
`timescale 1ns/1ps
module cfg_rx_frontend_tb_top;
    localparam time CLK_PERIOD = 100ns;
    localparam int  CLK_HZ  = 10_000_000;
    localparam int  BAUD    = 57_600;
    localparam int  BIT_CYC = (CLK_HZ + BAUD / 2) / BAUD;
    localparam int  TMO     = 512;
    localparam int  BLK     = 4;

    logic clk = 1'b0;
    logic ext_rst_n = 1'b0, clk_locked = 1'b0;
    logic uart_rx = 1'b1, bb_sclk = 1'b0, bb_sdata = 1'b0, par_valid = 1'b0;
    logic [7:0] par_data = '0;
    logic cfg_valid, frame_err, xfer_active, rx_led;
    logic [7:0] cfg_data;
    logic [1:0] cfg_src;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_rx_frontend #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .IDLE_TIMEOUT(TMO), .BLINK_LOG2(BLK)) dut_i (
        .clk(clk), .ext_rst_n(ext_rst_n), .clk_locked(clk_locked), .uart_rx(uart_rx),
        .bb_sclk(bb_sclk), .bb_sdata(bb_sdata), .par_valid(par_valid), .par_data(par_data),
        .cfg_valid(cfg_valid), .cfg_data(cfg_data), .cfg_src(cfg_src),
        .frame_err(frame_err), .xfer_active(xfer_active), .rx_led(rx_led)
    );

    int n_chk = 0, n_bad = 0;
    logic [7:0] cap_d [0:511];
    logic [1:0] cap_s [0:511];
    int cap_n = 0, ferr_n = 0;
    logic [7:0] exp_d [0:511];
    logic [1:0] exp_s [0:511];
    int exp_n = 0, cmp_i = 0;
    bit finished = 0;

    always @(negedge clk) begin
        if (cfg_valid && cap_n < 512) begin
            cap_d[cap_n] = cfg_data;
            cap_s[cap_n] = cfg_src;
            cap_n++;
        end
        if (frame_err) ferr_n++;
    end

    function automatic logic [1:0] src_code(int op);
        return (op == 0) ? 2'b01 : (op == 1) ? 2'b10 : 2'b11;
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic expect_byte(logic [7:0] d, logic [1:0] s);
        exp_d[exp_n] = d; exp_s[exp_n] = s; exp_n++;
    endtask

    task automatic compare(string req);
        repeat (20) @(negedge clk);
        check(cap_n == exp_n, {req, " byte count"}, cap_n, exp_n);
        while (cmp_i < exp_n && cmp_i < cap_n) begin
            check(cap_d[cmp_i] == exp_d[cmp_i], {req, " data"}, cap_d[cmp_i], exp_d[cmp_i]);
            check(cap_s[cmp_i] == exp_s[cmp_i], {req, " R2 source"}, cap_s[cmp_i], exp_s[cmp_i]);
            cmp_i++;
        end
        cmp_i = exp_n;
        cap_n = exp_n;
    endtask

    task automatic uart_send(logic [7:0] b, bit stop_ok);
        @(negedge clk) uart_rx = 1'b0;
        repeat (BIT_CYC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            uart_rx = b[i];
            repeat (BIT_CYC) @(negedge clk);
        end
        uart_rx = stop_ok;
        repeat (BIT_CYC) @(negedge clk);
        uart_rx = 1'b1;
        repeat (2 * BIT_CYC) @(negedge clk);
    endtask

    task automatic bb_send(logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk) bb_sdata = b[i];
            repeat (4) @(negedge clk);
            bb_sclk = 1'b1;
            repeat (4) @(negedge clk);
            bb_sclk = 1'b0;
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic par_send(logic [7:0] b);
        @(negedge clk) begin par_valid = 1'b1; par_data = b; end
        @(negedge clk) par_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int ops, toggles;
        logic prev_led;
        logic [7:0] b;
        void'($urandom(32'h1C0F_5EED));

        // R10: reset state and traffic while lock is missing
        repeat (5) @(negedge clk);
        check(cfg_valid == 0, "R10 valid in reset", cfg_valid, 0);
        check(xfer_active == 0, "R10 active in reset", xfer_active, 0);
        ext_rst_n = 1'b1;
        repeat (5) @(negedge clk);
        par_send(8'hA5);
        compare("R10 no lock");
        clk_locked = 1'b1;
        repeat (5) @(negedge clk);

        // R7: parallel byte alone
        par_send(8'h3C); expect_byte(8'h3C, 2'b11);
        compare("R7 parallel");
        // R3: serial byte alone
        uart_send(8'hD2, 1'b1); expect_byte(8'hD2, 2'b01);
        compare("R3 serial");
        // R6: two-wire byte alone, MSB first
        bb_send(8'h81); expect_byte(8'h81, 2'b10);
        compare("R6 two-wire");

        // random mix, one source at a time
        for (int k = 0; k < 18; k++) begin
            ops = $urandom % 3;
            b   = 8'($urandom);
            case (ops)
                0: uart_send(b, 1'b1);
                1: bb_send(b);
                default: par_send(b);
            endcase
            expect_byte(b, src_code(ops));
            repeat (4) @(negedge clk);
        end
        compare("R2 random mix");

        // R1: two-wire and parallel attempted inside a serial frame
        fork
            uart_send(8'h5A, 1'b1);
            begin repeat (300) @(negedge clk); bb_send(8'hFF); end
            begin repeat (900) @(negedge clk); par_send(8'h11); end
        join
        expect_byte(8'h5A, 2'b01);
        compare("R1 serial wins");

        // R1: parallel inside a two-wire byte
        fork
            bb_send(8'h6E);
            begin repeat (30) @(negedge clk); par_send(8'h22); end
        join
        expect_byte(8'h6E, 2'b10);
        compare("R1 two-wire over parallel");

        // R4: short glitch
        @(negedge clk) uart_rx = 1'b0;
        repeat (20) @(negedge clk);
        uart_rx = 1'b1;
        repeat (3 * BIT_CYC) @(negedge clk);
        compare("R4 glitch");
        check(ferr_n == 0, "R4 no framing error", ferr_n, 0);

        // R5: bad stop bit
        uart_send(8'h99, 1'b0);
        compare("R5 bad stop");
        check(ferr_n == 1, "R5 framing pulse count", ferr_n, 1);

        // R8 / R9: activity window and LED
        par_send(8'h77); expect_byte(8'h77, 2'b11);
        compare("R8 arm");
        repeat (TMO - 60) @(negedge clk);
        check(xfer_active == 1, "R8 still active", xfer_active, 1);
        check(rx_led == 1, "R9 solid led", rx_led, 1);
        repeat (80) @(negedge clk);
        check(xfer_active == 0, "R8 timed out", xfer_active, 0);
        toggles = 0;
        prev_led = rx_led;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (rx_led != prev_led) toggles++;
            prev_led = rx_led;
        end
        check(toggles >= 4 && toggles <= 5, "R9 idle blink", toggles, 5);

        finish_run();
    end
endmodule